// File: doc/BRIEF.md
# Sixteen-bit timer with compare match

This block is a 16-bit up-counter with a compare unit. Software reaches it through a small byte-wide register port. The count pulses come from the system clock or from a one-cycle strobe input. They pass through a power-of-two prescaler, and the counter advances only while the run bit is set.

On every count the compare unit checks the counter against a 16-bit compare value. A 4-bit mode field sets what a match does:

- `4'b1010` raises the compare flag only and leaves the counter free-running. Software can then add N to the compare value after each match, modulo 2^16, to get a tick every N counts.
- `4'b1011` raises the flag and also returns the counter to zero. This gives a period of compare+1 counts.

A separate overflow flag records each natural wrap of the counter. The interrupt output combines the two flags with their enables. Both compare modes leave any output pin alone, and the block has no pin output.

The register map uses byte addresses:

| Address | Contents |
|---|---|
| 0 | Control |
| 1 | Mode |
| 2 | Counter low byte |
| 3 | Counter high byte |
| 4 | Compare low byte |
| 5 | Compare high byte |
| 6 | Flags: bit 0 compare, bit 1 overflow |
| 7 | Enables: bit 0 compare, bit 1 overflow |

The control byte holds the following fields:

| Bits | Field |
|---|---|
| 7:6 | Source |
| 5:4 | Prescale select |
| 3 | Oscillator enable (stored only) |
| 2 | Active-low sync (stored only) |
| 1 | Reserved |
| 0 | Run |

Reads are combinational and have no side effects.

Top module: `cmp_timer`

## Requirements
- R1: After reset every register reads 0x00 and `irq` is 0.
- R2: The control byte reads back as written, except that bit 1 always reads 0. The mode register reads back only its low nibble, and its bits 7:4 read 0.
- R3: With run (control bit 0) at 1, the counter counts once per clock when control bit 7 is 0. It counts once per cycle with `ext_tick` high when control bit 7 is 1. With run at 0 the counter holds its value.
- R4: Prescale select values 0, 1, 2 and 3 (control bits 5:4) produce one count per 1, 2, 4 and 8 source pulses. Any write to the control register restarts the prescaler from zero.
- R5: In mode 4'b1010 the compare flag (flags bit 0) sets on the count that makes the counter equal the compare value. The counter keeps incrementing, and advancing the compare value by N after each match gives a match every N counts, including across the wrap.
- R6: In mode 4'b1011 the compare flag sets when the counter reaches the compare value, and the following count makes the counter 0.
- R7: In every mode other than 4'b1010 and 4'b1011 the compare flag never sets and the counter is not cleared.
- R8: The overflow flag (flags bit 1) sets on a count that takes the counter from 0xFFFF to 0x0000. It does so independently of the compare flag.
- R9: Each flag stays set until software writes 0 to its bit in the flags register. Writing 1 leaves the flag unchanged.
- R10: `irq` equals (compare flag AND enables bit 0) OR (overflow flag AND enables bit 1).
- R11: A write to a counter byte replaces that byte, and no count takes place in that cycle. A new compare value applies from the next count.
- R12: A counter that stops at the compare value does not set the compare flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| ext_tick | input | 1 | External count strobe, one cycle per pulse, in the `clk` domain |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is software advancing the compare value by N across the 16-bit wrap in free-running mode. Each match must land exactly N counts after the previous one, while the overflow flag sets between matches.

The bench loads the counter just below 0xFFFF and the compare value a few counts above it. It then polls the flags every clock, clears the compare flag and writes the two compare bytes. N is chosen larger than the three write cycles the update costs.

A second hard case is a counter standing at the compare value with no further counts. This is reached by driving a fixed number of external strobes and then withholding them.

// File: rtl/cmt_pkg.sv
// Shared constants and types for the compare-match timer.
// Assumes a byte-wide register port and a counter of two register bytes.
package cmt_pkg;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 2 * DATA_W;
    localparam int MODE_W = 4;
    localparam int PSEL_W = 2;
    localparam int ADDR_W = 3;

    localparam logic [MODE_W-1:0] MODE_MATCH_FLAG  = 4'b1010;
    localparam logic [MODE_W-1:0] MODE_MATCH_CLEAR = 4'b1011;

    localparam int FLAG_CMP = 0;
    localparam int FLAG_OVF = 1;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 3'd0,
        A_MODE   = 3'd1,
        A_CNT_LO = 3'd2,
        A_CNT_HI = 3'd3,
        A_CMP_LO = 3'd4,
        A_CMP_HI = 3'd5,
        A_FLAGS  = 3'd6,
        A_IEN    = 3'd7
    } cmt_addr_e;

    typedef struct packed {
        logic [1:0]        src;
        logic [PSEL_W-1:0] psel;
        logic              osc_en;
        logic              sync_n;
        logic              rsvd;
        logic              run;
    } cmt_ctrl_t;
endpackage

// File: rtl/cmt_prescaler.sv
// Power-of-two prescaler: passes one of every 2**sel input pulses.
// Assumes tick_in is a one-cycle qualifier; clear takes priority.
module cmt_prescaler
    import cmt_pkg::*;
#(
    parameter int SEL_W = PSEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick_in,
    input  logic [SEL_W-1:0] sel,
    output logic             tick_out
);
    localparam int DIV_W = (1 << SEL_W) - 1;

    logic [DIV_W-1:0] ps_q;
    logic [DIV_W-1:0] mask;

    // Build the terminal-count mask for the selected divisor.
    always_comb begin
        mask = DIV_W'((32'd1 << sel) - 32'd1);
    end

    // Emit a count when the low sel bits of the phase are all ones.
    always_comb begin
        tick_out = tick_in && ((ps_q & mask) == mask);
    end

    // Advance the phase on every input pulse, restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_q <= '0;
        end else if (clear) begin
            ps_q <= '0;
        end else if (tick_in) begin
            ps_q <= ps_q + 1'b1;
        end
    end
endmodule

// File: rtl/cmt_counter.sv
// Counter with compare and wrap detection.
// A byte write replaces that byte and suppresses the count in that cycle.
// A match is detected when the next value equals the compare value.
module cmt_counter
    import cmt_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int DW = DATA_W,
    parameter int MW = MODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_en,
    input  logic [MW-1:0] mode,
    input  logic [CW-1:0] cmp_val,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [DW-1:0] wdata,
    output logic [CW-1:0] cnt_q,
    output logic          match_evt,
    output logic          ovf_evt
);
    logic          eff_en;
    logic          compare_on;
    logic          clear_path;
    logic [CW-1:0] cnt_next;

    // Decide the next counter value and the events of this count.
    always_comb begin
        eff_en     = cnt_en && !(wr_lo || wr_hi);
        compare_on = (mode == MODE_MATCH_FLAG) || (mode == MODE_MATCH_CLEAR);
        clear_path = eff_en && (mode == MODE_MATCH_CLEAR) && (cnt_q == cmp_val);
        cnt_next   = clear_path ? '0 : cnt_q + 1'b1;
        match_evt  = eff_en && compare_on && (cnt_next == cmp_val);
        ovf_evt    = eff_en && !clear_path && (&cnt_q);
    end

    // Hold, load a byte or count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_lo) begin
            cnt_q[DW-1:0] <= wdata;
        end else if (wr_hi) begin
            cnt_q[CW-1:DW] <= wdata;
        end else if (eff_en) begin
            cnt_q <= cnt_next;
        end
    end
endmodule

// File: rtl/cmt_regs.sv
// Register file: control, mode, compare, flags, enables and read mux.
// A hardware set of a flag wins over a software clear in the same cycle.
module cmt_regs
    import cmt_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CNT_W,
    parameter int MW = MODE_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    input  logic          match_evt,
    input  logic          ovf_evt,
    input  logic [CW-1:0] cnt_q,
    output cmt_ctrl_t     ctrl_q,
    output logic [MW-1:0] mode_q,
    output logic [CW-1:0] cmp_q,
    output logic [1:0]    flags_q,
    output logic [1:0]    ien_q,
    output logic          ctrl_wr,
    output logic          cnt_wr_lo,
    output logic          cnt_wr_hi,
    output logic [DW-1:0] reg_rdata,
    output logic          irq
);
    cmt_addr_e addr;
    logic      wr_mode;
    logic      wr_cmp_lo;
    logic      wr_cmp_hi;
    logic      wr_flags;
    logic      wr_ien;

    // Decode the write strobes per register.
    always_comb begin
        addr      = cmt_addr_e'(reg_addr);
        ctrl_wr   = reg_wr && (addr == A_CTRL);
        wr_mode   = reg_wr && (addr == A_MODE);
        cnt_wr_lo = reg_wr && (addr == A_CNT_LO);
        cnt_wr_hi = reg_wr && (addr == A_CNT_HI);
        wr_cmp_lo = reg_wr && (addr == A_CMP_LO);
        wr_cmp_hi = reg_wr && (addr == A_CMP_HI);
        wr_flags  = reg_wr && (addr == A_FLAGS);
        wr_ien    = reg_wr && (addr == A_IEN);
    end

    // Store control and mode; the reserved control bit is kept at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mode_q <= '0;
        end else begin
            if (ctrl_wr) begin
                ctrl_q      <= cmt_ctrl_t'(reg_wdata);
                ctrl_q.rsvd <= 1'b0;
            end
            if (wr_mode) begin
                mode_q <= reg_wdata[MW-1:0];
            end
        end
    end

    // Store the compare value byte by byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else if (wr_cmp_lo) begin
            cmp_q[DW-1:0] <= reg_wdata;
        end else if (wr_cmp_hi) begin
            cmp_q[CW-1:DW] <= reg_wdata;
        end
    end

    // Sticky flags: set by events, cleared only by writing zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            if (match_evt) begin
                flags_q[FLAG_CMP] <= 1'b1;
            end else if (wr_flags && !reg_wdata[FLAG_CMP]) begin
                flags_q[FLAG_CMP] <= 1'b0;
            end
            if (ovf_evt) begin
                flags_q[FLAG_OVF] <= 1'b1;
            end else if (wr_flags && !reg_wdata[FLAG_OVF]) begin
                flags_q[FLAG_OVF] <= 1'b0;
            end
        end
    end

    // Store the interrupt enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q <= '0;
        end else if (wr_ien) begin
            ien_q <= reg_wdata[1:0];
        end
    end

    // Combine the enabled flags into the request.
    always_comb begin
        irq = |(flags_q & ien_q);
    end

    // Return the addressed register.
    always_comb begin
        case (addr)
            A_CTRL:   reg_rdata = ctrl_q;
            A_MODE:   reg_rdata = {{(DW-MW){1'b0}}, mode_q};
            A_CNT_LO: reg_rdata = cnt_q[DW-1:0];
            A_CNT_HI: reg_rdata = cnt_q[CW-1:DW];
            A_CMP_LO: reg_rdata = cmp_q[DW-1:0];
            A_CMP_HI: reg_rdata = cmp_q[CW-1:DW];
            A_FLAGS:  reg_rdata = {{(DW-2){1'b0}}, flags_q};
            default:  reg_rdata = {{(DW-2){1'b0}}, ien_q};
        endcase
    end
endmodule

// File: rtl/cmp_timer.sv
// Top of the compare-match timer.
// Assumes ext_tick is a single-cycle strobe already in the clk domain.
module cmp_timer
    import cmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ext_tick,
    output logic              irq
);
    cmt_ctrl_t         ctrl_q;
    logic [MODE_W-1:0] mode_q;
    logic [CNT_W-1:0]  cmp_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [1:0]        flags_q;
    logic [1:0]        ien_q;
    logic              ctrl_wr;
    logic              cnt_wr_lo;
    logic              cnt_wr_hi;
    logic              match_evt;
    logic              ovf_evt;
    logic              run;
    logic              src_pulse;
    logic              cnt_en;

    // Pick the pulse source and qualify it with the run bit.
    always_comb begin
        run       = ctrl_q.run;
        src_pulse = ctrl_q.src[1] ? ext_tick : 1'b1;
    end

    cmt_prescaler #(.SEL_W(PSEL_W)) u_psc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (ctrl_wr),
        .tick_in  (run && src_pulse),
        .sel      (ctrl_q.psel),
        .tick_out (cnt_en)
    );

    cmt_counter #(.CW(CNT_W), .DW(DATA_W), .MW(MODE_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_en    (cnt_en),
        .mode      (mode_q),
        .cmp_val   (cmp_q),
        .wr_lo     (cnt_wr_lo),
        .wr_hi     (cnt_wr_hi),
        .wdata     (reg_wdata),
        .cnt_q     (cnt_q),
        .match_evt (match_evt),
        .ovf_evt   (ovf_evt)
    );

    cmt_regs #(.DW(DATA_W), .CW(CNT_W), .MW(MODE_W), .AW(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .match_evt (match_evt),
        .ovf_evt   (ovf_evt),
        .cnt_q     (cnt_q),
        .ctrl_q    (ctrl_q),
        .mode_q    (mode_q),
        .cmp_q     (cmp_q),
        .flags_q   (flags_q),
        .ien_q     (ien_q),
        .ctrl_wr   (ctrl_wr),
        .cnt_wr_lo (cnt_wr_lo),
        .cnt_wr_hi (cnt_wr_hi),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );
endmodule

// File: rtl/cmp_timer_chk.sv
// Property checker for the compare-match timer, bound to the top.
module cmp_timer_chk
    import cmt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              run,
    input logic              cnt_en,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [CNT_W-1:0]  cmp_q,
    input logic [MODE_W-1:0] mode_q,
    input logic [1:0]        flags_q,
    input logic              irq
);
    logic cnt_wr;
    logic flag_clr;

    // Port-level view of counter writes and compare-flag clears.
    always_comb begin
        cnt_wr   = reg_wr && ((reg_addr == A_CNT_LO) || (reg_addr == A_CNT_HI));
        flag_clr = reg_wr && (reg_addr == A_FLAGS) && !reg_wdata[FLAG_CMP];
    end

    // R9
    cmp_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q[FLAG_CMP] && !flag_clr) |=> flags_q[FLAG_CMP]);

    // R3
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr) |=> $stable(cnt_q));

    // R6
    clear_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !cnt_wr && mode_q == MODE_MATCH_CLEAR && cnt_q == cmp_q)
        |=> (cnt_q == '0));

    // R5
    free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !cnt_wr && mode_q == MODE_MATCH_FLAG)
        |=> (cnt_q == $past(cnt_q) + 16'd1));

    // R8
    overflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !cnt_wr && (&cnt_q) &&
         !(mode_q == MODE_MATCH_CLEAR && cmp_q == cnt_q))
        |=> flags_q[FLAG_OVF]);

    // R10
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q == 2'b00) |-> !irq);
endmodule

bind cmp_timer cmp_timer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .run       (run),
    .cnt_en    (cnt_en),
    .cnt_q     (cnt_q),
    .cmp_q     (cmp_q),
    .mode_q    (mode_q),
    .flags_q   (flags_q),
    .irq       (irq)
);

// File: tb/cmp_timer_tb.sv
// Self-checking bench for the compare-match timer.
module cmp_timer_tb;
    import cmt_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       ext_tick = 1'b0;
    logic       irq;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    cmp_timer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ext_tick  (ext_tick),
        .irq       (irq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // One write: the posedge in between samples it.
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic rd_cnt(output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(A_CNT_LO, lo);
        rd(A_CNT_HI, hi);
        v = {hi, lo};
    endtask

    task automatic setup(input logic [15:0] c, input logic [15:0] m, input logic [3:0] md);
        wr(A_CTRL, 8'h00);
        wr(A_MODE, {4'h0, md});
        wr(A_CMP_LO, m[7:0]);
        wr(A_CMP_HI, m[15:8]);
        wr(A_CNT_LO, c[7:0]);
        wr(A_CNT_HI, c[15:8]);
        wr(A_FLAGS, 8'h00);
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0]  d;
        logic [15:0] v;
        logic [15:0] m;
        logic [15:0] cmpv;
        int          pulses;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of every register and the request
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            chk("R1 reset register", {8'h00, d}, 16'h0000);
        end
        chk("R1 reset irq", {15'd0, irq}, 16'd0);

        // R2: control and mode readback sweeps
        for (int x = 0; x < 256; x++) begin
            wr(A_CTRL, 8'(x));
            rd(A_CTRL, d);
            chk("R2 control readback", {8'h00, d}, 16'(x & 8'hFD));
        end
        for (int x = 0; x < 256; x++) begin
            wr(A_MODE, 8'(x));
            rd(A_MODE, d);
            chk("R2 mode readback", {8'h00, d}, 16'(x & 8'h0F));
        end

        // R4 and R3: internal source, every prescale value
        for (int s = 0; s < 4; s++) begin
            setup(16'h0000, 16'h0000, 4'h0);
            wr(A_CTRL, 8'((s << 4) | 1));
            repeat (20) @(negedge clk);
            rd_cnt(v);
            chk("R4 prescale count", v, 16'(20 >> s));
        end

        // R3: a stopped counter holds
        wr(A_CTRL, 8'h00);
        rd_cnt(v);
        repeat (10) @(negedge clk);
        rd_cnt(m);
        chk("R3 hold when stopped", m, v);

        // R4: a control write restarts the prescaler
        setup(16'h0000, 16'h0000, 4'h0);
        wr(A_CTRL, 8'h21);
        repeat (6) @(negedge clk);
        wr(A_CTRL, 8'h21);
        repeat (3) @(negedge clk);
        rd_cnt(v);
        chk("R4 prescaler restart", v, 16'd1);
        @(negedge clk);
        rd_cnt(v);
        chk("R4 prescaler restart next", v, 16'd2);

        // R3 and R4: external strobe source, divide by 1 and 4
        for (int s = 0; s < 3; s += 2) begin
            setup(16'h0000, 16'h0000, 4'h0);
            wr(A_CTRL, 8'(8'h81 | (s << 4)));
            pulses = 0;
            for (int i = 0; i < 30; i++) begin
                ext_tick = ((i % 3) != 1);
                if ((i % 3) != 1) pulses++;
                @(negedge clk);
            end
            ext_tick = 1'b0;
            rd_cnt(v);
            chk("R3 external source count", v, 16'(pulses >> s));
        end

        // R5: flag-only match keeps the counter running
        setup(16'h0000, 16'h0010, 4'hA);
        wr(A_CTRL, 8'h01);
        repeat (15) @(negedge clk);
        rd(A_FLAGS, d);
        chk("R5 no flag before match", {8'h00, d}, 16'h0000);
        @(negedge clk);
        rd(A_FLAGS, d);
        rd_cnt(v);
        chk("R5 flag at match", {8'h00, d}, 16'h0001);
        chk("R5 counter at match", v, 16'h0010);
        repeat (4) @(negedge clk);
        rd_cnt(v);
        chk("R5 counter continues", v, 16'h0014);

        // R5 and R8: software advances the compare value across the wrap
        setup(16'hFFE0, 16'hFFE8, 4'hA);
        cmpv = 16'hFFE8;
        wr(A_CTRL, 8'h01);
        for (int k = 0; k < 5; k++) begin
            d = 8'h00;
            for (int i = 0; i < 64; i++) begin
                rd(A_FLAGS, d);
                if (d[0]) break;
                @(negedge clk);
            end
            rd_cnt(v);
            chk("R5 periodic match value", v, cmpv);
            cmpv = cmpv + 16'h000B;
            wr(A_FLAGS, 8'h02);
            wr(A_CMP_LO, cmpv[7:0]);
            wr(A_CMP_HI, cmpv[15:8]);
        end
        rd(A_FLAGS, d);
        chk("R8 overflow seen during periodic run", {15'd0, d[1]}, 16'd1);

        // R6: clear-on-match, cycle by cycle against a model
        setup(16'h0000, 16'h0009, 4'hB);
        wr(A_CTRL, 8'h01);
        m = 16'h0000;
        for (int i = 1; i <= 40; i++) begin
            @(negedge clk);
            m = (m == 16'h0009) ? 16'h0000 : m + 16'd1;
            rd_cnt(v);
            chk("R6 clear-on-match counter", v, m);
            if (i == 9) begin
                rd(A_FLAGS, d);
                chk("R6 flag at match", {8'h00, d}, 16'h0001);
            end
        end

        // R7: other modes never flag and never clear
        for (int md = 0; md < 16; md++) begin
            if (md == 10 || md == 11) continue;
            setup(16'h0000, 16'h0003, 4'(md));
            wr(A_CTRL, 8'h01);
            repeat (8) @(negedge clk);
            rd(A_FLAGS, d);
            rd_cnt(v);
            chk("R7 no compare flag", {15'd0, d[0]}, 16'd0);
            chk("R7 counter not cleared", v, 16'd8);
        end

        // R8: wrap sets overflow independently of the compare flag
        setup(16'hFFFD, 16'h0002, 4'hA);
        wr(A_CTRL, 8'h01);
        repeat (2) @(negedge clk);
        rd(A_FLAGS, d);
        rd_cnt(v);
        chk("R8 before wrap counter", v, 16'hFFFF);
        chk("R8 before wrap flags", {8'h00, d}, 16'h0000);
        @(negedge clk);
        rd(A_FLAGS, d);
        rd_cnt(v);
        chk("R8 wrap counter", v, 16'h0000);
        chk("R8 wrap flags", {8'h00, d}, 16'h0002);
        repeat (2) @(negedge clk);
        rd(A_FLAGS, d);
        chk("R8 both flags", {8'h00, d}, 16'h0003);
        wr(A_CTRL, 8'h00);

        // R10 and R9: interrupt combination and sticky flags
        for (int e = 0; e < 4; e++) begin
            wr(A_IEN, 8'(e));
            chk("R10 irq both flags", {15'd0, irq}, 16'(e != 0));
        end
        wr(A_FLAGS, 8'h03);
        rd(A_FLAGS, d);
        chk("R9 writing ones keeps flags", {8'h00, d}, 16'h0003);
        wr(A_FLAGS, 8'h02);
        rd(A_FLAGS, d);
        chk("R9 clear compare only", {8'h00, d}, 16'h0002);
        for (int e = 0; e < 4; e++) begin
            wr(A_IEN, 8'(e));
            chk("R10 irq overflow only", {15'd0, irq}, 16'((e >> 1) & 1));
        end
        wr(A_FLAGS, 8'h00);
        chk("R10 irq no flags", {15'd0, irq}, 16'd0);
        wr(A_IEN, 8'h00);

        // R11: counter write wins over a count
        setup(16'h0000, 16'h0000, 4'h0);
        wr(A_CTRL, 8'h01);
        repeat (5) @(negedge clk);
        wr(A_CNT_LO, 8'h55);
        rd_cnt(v);
        chk("R11 write overrides count", v, 16'h0055);
        @(negedge clk);
        rd_cnt(v);
        chk("R11 count resumes", v, 16'h0056);

        // R12: counter parked on the compare value does not re-flag
        setup(16'h0000, 16'h0002, 4'hA);
        wr(A_CTRL, 8'h81);
        for (int i = 0; i < 2; i++) begin
            ext_tick = 1'b1;
            @(negedge clk);
            ext_tick = 1'b0;
        end
        rd(A_FLAGS, d);
        chk("R12 first match flag", {8'h00, d}, 16'h0001);
        wr(A_FLAGS, 8'h00);
        repeat (10) @(negedge clk);
        rd(A_FLAGS, d);
        rd_cnt(v);
        chk("R12 no repeat flag", {8'h00, d}, 16'h0000);
        chk("R12 counter parked", v, 16'h0002);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule